// File: doc/BRIEF.md
# Center-Aligned PWM Generator Built on a Sawtooth Counter

This block makes a symmetric, center-aligned pulse train while its counter only ever counts upward. A prescaler divides the clock into base ticks, and a frame counter counts those ticks from zero up to the programmed frame length, then wraps and keeps running. Frames alternate between even and odd. In an even frame the pulse sits at the start of the frame. In an odd frame the comparison is mirrored and the pulse sits at the end. Two frames placed back to back therefore give one pulse that is centred on their common boundary, which is what an up/down triangle counter would give.

The duty input is sampled at every frame boundary, so it is updated twice per equivalent triangle period. At that same boundary the block takes the base period and the frame length into shadow registers, works out the compare value for the new frame and flips the polarity, all on one clock edge. A one-clock frame-end strobe and a phase flag let converters or a control loop lock onto the frame timing. The counter is never reset while enable is high.

Top module: `cpwm_top`

## Requirements
- R1: The frame counter advances once every `base_period` clocks. A `base_period` of 0 behaves like 1, which means one advance per clock.
- R2: A frame lasts `frame_len` base ticks, with the count running from 0 to `frame_len`-1 and then wrapping to 0. A `frame_len` of 0 behaves like 1.
- R3: In an even frame (`phase_odd`=0), `pwm_out` is 1 exactly while the count is below the saturated duty, min(`duty`, `frame_len`).
- R4: In an odd frame (`phase_odd`=1), `pwm_out` is 1 exactly while the count is at or above `frame_len` minus the saturated duty.
- R5: `phase_odd` is 0 in the first frame after enable and toggles at each frame boundary. The toggle happens on the same clock edge on which the new compare value takes effect.
- R6: `frame_end` is 1 for exactly the last clock of every frame. That is the clock where the prescaler is at `base_period`-1 and the count is at `frame_len`-1.
- R7: `base_period`, `frame_len` and `duty` are taken only at the start of a frame. A change made mid-frame takes effect in the next frame.
- R8: A duty of 0 gives a constant low output and a duty at or above `frame_len` gives a constant high output, in both phases.
- R9: While `enable` is 0, `pwm_out`, `frame_end` and `phase_odd` are 0. On the first clock edge with `enable` at 1, the block starts frame 0 at count 0, prescaler position 0, and its outputs already show that position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run enable; low holds the block idle |
| base_period | input | 8 | Clocks per base tick (0 behaves like 1) |
| frame_len | input | 16 | Base ticks per frame (0 behaves like 1) |
| duty | input | 16 | Pulse width in base ticks per frame |
| pwm_out | output | 1 | Registered PWM level |
| frame_end | output | 1 | High on the last clock of each frame |
| phase_odd | output | 1 | Parity of the frame in progress |

## Verification
The polarity flip and the capture of a new compare value fall on the same clock edge as the counter wrap. A glitch would therefore show up as a wrong `pwm_out` level in the first clock of a frame. The bench sweeps every small combination of base period, frame length and duty, including the saturated values, and the mirrored output makes the first clock of each frame sensitive to both the phase and the compare. A second test changes `duty` on most clocks of a run, including on the boundary clock itself. Each clock is then compared against the level worked out from the values the bench saw at the last boundary.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    parameter int PRE_W = 8;
    parameter int FRM_W = 16;

    typedef struct packed {
        logic [FRM_W-1:0] cnt;
        logic             phase;
        logic [PRE_W-1:0] base;
        logic [FRM_W-1:0] frame;
        logic [FRM_W-1:0] duty;
        logic [FRM_W-1:0] cmp;
    } seq_t;

    typedef struct packed {
        logic pwm;
        logic fend;
        logic odd;
    } out_t;

    function automatic logic [PRE_W-1:0] eff_base(input logic [PRE_W-1:0] b);
        return (b == '0) ? PRE_W'(1) : b;
    endfunction

    function automatic logic [FRM_W-1:0] eff_frame(input logic [FRM_W-1:0] f);
        return (f == '0) ? FRM_W'(1) : f;
    endfunction

    function automatic logic [FRM_W-1:0] sat_duty(input logic [FRM_W-1:0] d,
                                                  input logic [FRM_W-1:0] n);
        return (d > n) ? n : d;
    endfunction

endpackage

// File: rtl/cpwm_prescale.sv
module cpwm_prescale
    import cpwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             start,
    input  logic [PRE_W-1:0] base_q,
    output logic             tick,
    output logic [PRE_W-1:0] pre_d
);

    logic [PRE_W-1:0] pre_q;

    always_comb begin
        tick  = (pre_q == base_q - PRE_W'(1));
        pre_d = pre_q + PRE_W'(1);
        if (!enable || start || tick) begin
            pre_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q < base_q) else $error("prescaler out of range"); // R1

endmodule

// File: rtl/cpwm_frame_seq.sv
module cpwm_frame_seq
    import cpwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             start,
    input  logic             tick,
    input  logic [PRE_W-1:0] base_in,
    input  logic [FRM_W-1:0] frame_in,
    input  logic [FRM_W-1:0] duty_in,
    output seq_t             seq_q,
    output seq_t             seq_d
);

    logic             last;
    logic             wrap;
    logic [FRM_W-1:0] n_new;
    logic [FRM_W-1:0] d_new;

    always_comb begin
        last  = tick && (seq_q.cnt == seq_q.frame - FRM_W'(1));
        wrap  = enable && !start && last;
        n_new = eff_frame(frame_in);
        d_new = sat_duty(duty_in, n_new);
        seq_d = seq_q;
        if (!enable || start || wrap) begin
            seq_d.cnt   = '0;
            seq_d.phase = wrap ? ~seq_q.phase : 1'b0;
            seq_d.base  = eff_base(base_in);
            seq_d.frame = n_new;
            seq_d.duty  = d_new;
            seq_d.cmp   = (wrap && !seq_q.phase) ? (n_new - d_new) : d_new;
        end else if (tick) begin
            seq_d.cnt = seq_q.cnt + FRM_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.base  <= PRE_W'(1);
            seq_q.frame <= FRM_W'(1);
        end else begin
            seq_q <= seq_d;
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.cnt < seq_q.frame) else $error("count beyond frame"); // R2
    AST_FLIP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase != $past(seq_q.phase)) |-> (seq_q.cnt == '0)) else $error("phase moved mid-frame"); // R5
    AST_HOLD_SETTINGS: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !start && !last) |=> ($stable(seq_q.duty) && $stable(seq_q.frame) && $stable(seq_q.base))) else $error("settings moved mid-frame"); // R7

endmodule

// File: rtl/cpwm_out_stage.sv
module cpwm_out_stage
    import cpwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  seq_t             seq_d,
    input  logic [PRE_W-1:0] pre_d,
    output out_t             out_q
);

    out_t out_d;
    logic below;

    always_comb begin
        below      = seq_d.cnt < seq_d.cmp;
        out_d.pwm  = enable && (seq_d.phase ? !below : below);
        out_d.fend = enable && (pre_d == seq_d.base - PRE_W'(1))
                            && (seq_d.cnt == seq_d.frame - FRM_W'(1));
        out_d.odd  = enable && seq_d.phase;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (out_q == '0)) else $error("output active while idle"); // R9

endmodule

// File: rtl/cpwm_top.sv
module cpwm_top
    import cpwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [PRE_W-1:0] base_period,
    input  logic [FRM_W-1:0] frame_len,
    input  logic [FRM_W-1:0] duty,
    output logic             pwm_out,
    output logic             frame_end,
    output logic             phase_odd
);

    logic             run_q;
    logic             run_d;
    logic             start;
    logic             tick;
    logic [PRE_W-1:0] pre_d;
    seq_t             seq_q;
    seq_t             seq_d;
    out_t             out_q;

    always_comb begin
        run_d = enable;
        start = enable && !run_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= run_d;
    end

    cpwm_prescale u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .start  (start),
        .base_q (seq_q.base),
        .tick   (tick),
        .pre_d  (pre_d)
    );

    cpwm_frame_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .start    (start),
        .tick     (tick),
        .base_in  (base_period),
        .frame_in (frame_len),
        .duty_in  (duty),
        .seq_q    (seq_q),
        .seq_d    (seq_d)
    );

    cpwm_out_stage u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .seq_d  (seq_d),
        .pre_d  (pre_d),
        .out_q  (out_q)
    );

    assign pwm_out   = out_q.pwm;
    assign frame_end = out_q.fend;
    assign phase_odd = out_q.odd;

    AST_FEND_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (!frame_end || (seq_q.base == PRE_W'(1) && seq_q.frame == FRM_W'(1)))) else $error("frame_end too long"); // R6
    AST_PHASE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && enable) |=> (phase_odd != $past(phase_odd))) else $error("phase did not toggle"); // R5
    AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.duty == '0) |-> !pwm_out) else $error("zero duty drove high"); // R8

endmodule

// File: tb/cpwm_top_tb.sv
`timescale 1ns/1ps
module cpwm_top_tb;
    import cpwm_pkg::*;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b0;
    logic [PRE_W-1:0] base_period = '0;
    logic [FRM_W-1:0] frame_len = '0;
    logic [FRM_W-1:0] duty = '0;
    logic             pwm_out;
    logic             frame_end;
    logic             phase_odd;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string ctx = "";

    // bench model of the expected position
    bit m_run = 0;
    int m_pre = 0, m_cnt = 0, m_ph = 0;
    int m_b = 1, m_n = 1, m_d = 0;

    always #2 clk = ~clk;

    cpwm_top u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .base_period(base_period), .frame_len(frame_len), .duty(duty),
        .pwm_out(pwm_out), .frame_end(frame_end), .phase_odd(phase_odd)
    );

    task automatic load_settings();
        m_b = (base_period == 0) ? 1 : int'(base_period);
        m_n = (frame_len == 0) ? 1 : int'(frame_len);
        m_d = (int'(duty) > m_n) ? m_n : int'(duty);
    endtask

    always @(posedge clk) begin
        if (!rst_n || !enable) begin
            m_run = 0; m_pre = 0; m_cnt = 0; m_ph = 0;
        end else if (!m_run) begin
            m_run = 1; m_pre = 0; m_cnt = 0; m_ph = 0;
            load_settings();
        end else if (m_pre == m_b - 1) begin
            m_pre = 0;
            if (m_cnt == m_n - 1) begin
                m_cnt = 0; m_ph ^= 1;
                load_settings();
            end else begin
                m_cnt++;
            end
        end else begin
            m_pre++;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b (pre=%0d cnt=%0d ph=%0d B=%0d N=%0d D=%0d)",
                     tag, ctx, act, exp, m_pre, m_cnt, m_ph, m_b, m_n, m_d);
        end
    endtask

    task automatic check_cycle();
        logic e_pwm, e_fe, e_ph;
        string tag;
        e_pwm = m_run && (m_ph ? (m_cnt >= m_n - m_d) : (m_cnt < m_d));
        e_fe  = m_run && (m_pre == m_b - 1) && (m_cnt == m_n - 1);
        e_ph  = m_run && (m_ph != 0);
        if (!m_run)                        tag = "R9 idle pwm";
        else if (m_d == 0 || m_d >= m_n)   tag = "R8 saturated pwm";
        else if (m_ph != 0)                tag = "R4 odd pwm";
        else                               tag = "R3 even pwm";
        chk(tag, pwm_out, e_pwm);
        chk(m_run ? "R6 R1 R2 frame_end" : "R9 idle frame_end", frame_end, e_fe);
        chk(m_run ? "R5 phase" : "R9 idle phase", phase_odd, e_ph);
    endtask

    task automatic run_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_cycle();
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        ctx = "reset";
        run_cycles(3);
        @(negedge clk); rst_n = 1'b1;
        run_cycles(3);

        // sweep: R1 R2 R3 R4 R8 R9
        ctx = "sweep";
        for (int b = 0; b <= 3; b++) begin
            for (int n = 0; n <= 5; n++) begin
                for (int d = 0; d <= n + 1; d++) begin
                    base_period = PRE_W'(b);
                    frame_len   = FRM_W'(n);
                    duty        = FRM_W'(d);
                    enable      = 1'b1;
                    run_cycles(4 * ((b == 0) ? 1 : b) * ((n == 0) ? 1 : n) + 3);
                    enable      = 1'b0;
                    run_cycles(2);
                end
            end
        end

        // R7: duty and frame_len changed mid-frame, including on boundary clocks
        ctx = "R7 midframe";
        base_period = 2; frame_len = 6; duty = 1;
        enable = 1'b1;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            check_cycle();
            duty = FRM_W'((i * 7 + 3) % 9);
            if (i % 37 == 0) frame_len = FRM_W'(4 + (i % 3));
        end

        // R9: restart mid-frame begins again at frame 0
        ctx = "R9 restart";
        enable = 1'b0; duty = 2; frame_len = 5; base_period = 3;
        run_cycles(3);
        enable = 1'b1;
        run_cycles(40);
        enable = 1'b0;
        run_cycles(3);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule